// File: doc/BRIEF.md
# FIFO Status and Interrupt Controller

This block sits beside a pair of byte FIFOs (one for transmit, one for receive) in a serial controller. It holds the interrupt-enable register, the sticky interrupt-status register and the FIFO control and fill-level registers. It turns the live FIFO fill counts, a receive-overflow pulse and a transfer-done pulse into four status flags and one level-sensitive interrupt line. The FIFO storage and the shift engine are outside this block. It only sees their counts and drives their reset strobes.

Software programs two 8-bit trigger levels. The receive-ready flag is raised while the receive FIFO holds at least its trigger level. The transmit-request flag is raised while the transmit FIFO holds no more than its trigger level. All four flags are sticky and cleared by writing ones to them. A level flag whose condition still holds comes back one cycle after it is cleared. Writing the reset bits of the control register sends a one-cycle reset strobe to the matching FIFO. Those bits always read back as zero.

The register port is a simple single-cycle write with a combinational read. Word address 0 is the interrupt enable, 1 the interrupt status, 2 the FIFO control and 3 the FIFO fill levels. The FIFO depth is a parameter (64 or 128 bytes).

Top module: `fifo_irq_ctrl`

## Requirements
- R1: While reset is held, all status flags, enables, FIFO reset strobes and the interrupt are zero. Both trigger levels are 3/4 of DEPTH, so address 2 reads (TRIG<<16)|TRIG.
- R2: A write to address 0 stores the enables at bit 0 (receive ready), bit 4 (transmit request), bit 8 (receive overflow) and bit 12 (transfer done). Every other bit of address 0 reads as zero.
- R3: Status bit 0 (receive ready) is set one cycle after a cycle in which the receive count is at or above the receive trigger, held in bits [7:0] of address 2.
- R4: Status bit 4 (transmit request) is set one cycle after a cycle in which the transmit count is at or below the transmit trigger, held in bits [23:16] of address 2.
- R5: Status bit 8 captures a one-cycle receive-overflow pulse and bit 12 captures a one-cycle transfer-done pulse. Each stays set until software clears it.
- R6: Writing to address 1 clears every status bit written as one and leaves bits written as zero untouched. Writing all ones clears all four flags.
- R7: For the two level flags (bits 0 and 4), the clear wins in its write cycle. If the condition still holds, the flag reads zero for exactly one cycle and is set again on the next.
- R8: For the two event flags (bits 8 and 12), an event in the same cycle as a clear of that bit leaves the flag set.
- R9: The interrupt output is high exactly when some status bit is set together with its enable bit. It follows the registers with no added cycle.
- R10: Writing a one to bit 15 of address 2 drives the receive-FIFO reset strobe high for the one cycle after the write. Bit 31 does the same for the transmit FIFO. Both bits read back as zero.
- R11: Address 3 reads the live receive count in bits [CW-1:0] and the live transmit count in bits [16+CW-1:16], with CW = log2(DEPTH)+1. All other bits read as zero.
- R12: Address 1 reads the four flags at bits 0, 4, 8 and 12, and all other bits as zero. The flags_o port carries them as bits 0 to 3 in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 2 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| rx_level | input | log2(DEPTH)+1 | Receive FIFO fill count |
| tx_level | input | log2(DEPTH)+1 | Transmit FIFO fill count |
| rx_ovf_pulse | input | 1 | Receive overflow event, one cycle |
| xfer_done_pulse | input | 1 | Transfer complete event, one cycle |
| flags_o | output | 4 | Status flags: receive ready, transmit request, overflow, done |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO reset strobe |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO reset strobe |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the cycle where a clear meets a set. A level flag cleared while its FIFO is still past threshold must read low for one cycle and then return. A design that let the set win would never show the gap, and one that dropped the condition would stay low. An overflow or done pulse that lands on its own clear must survive; an ordering error loses the event. Counts equal to each trigger are driven to expose an off-by-one in the at-or-above and at-or-below compares. Repeated reset-bit writes check that the strobes last one cycle and never read back, while random mixes of enables and flags catch an interrupt that ignores a mask bit.

// File: rtl/fic_pkg.sv
package fic_pkg;

  localparam logic [1:0] ADDR_EN   = 2'd0;
  localparam logic [1:0] ADDR_STS  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_LVL  = 2'd3;

  localparam int NUM_FLAGS   = 4;
  localparam int FLAG_STRIDE = 4;
  localparam int RX_RST_BIT  = 15;
  localparam int TX_RST_BIT  = 31;
  localparam int TX_TRIG_LSB = 16;

  // Place flag i at bit 4*i of a register word.
  function automatic logic [31:0] spread_flags(input logic [NUM_FLAGS-1:0] f);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < NUM_FLAGS; i++) w[i*FLAG_STRIDE] = f[i];
    return w;
  endfunction

  // Gather bits 0,4,8,12 of a register word into a flag vector.
  function automatic logic [NUM_FLAGS-1:0] gather_flags(input logic [31:0] w);
    logic [NUM_FLAGS-1:0] f;
    for (int i = 0; i < NUM_FLAGS; i++) f[i] = w[i*FLAG_STRIDE];
    return f;
  endfunction

  function automatic logic fill_reached(input logic [8:0] cnt, input logic [8:0] lvl);
    return cnt >= lvl;
  endfunction

  function automatic logic fill_drained(input logic [8:0] cnt, input logic [8:0] lvl);
    return cnt <= lvl;
  endfunction

endpackage

// File: rtl/fic_flag_cell.sv
module fic_flag_cell #(
  parameter bit LEVEL_SRC = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  generate
    if (LEVEL_SRC) begin : g_level
      // Level source: clear has priority, the condition re-asserts next cycle.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (clr_i) flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
      end

      assert_lvl_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !flag_o);
    end else begin : g_event
      // Event source: a pulse coinciding with a clear is not lost.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
      end

      assert_evt_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);
    end
  endgenerate

  assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/fic_ctrl_regs.sv
module fic_ctrl_regs
  import fic_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_wr,
  input  logic       ctrl_wr,
  input  logic [3:0] en_wd,
  input  logic [7:0] rx_trig_wd,
  input  logic [7:0] tx_trig_wd,
  input  logic       rx_rst_wd,
  input  logic       tx_rst_wd,
  output logic [3:0] en_bits,
  output logic [7:0] rx_trig,
  output logic [7:0] tx_trig,
  output logic       rx_rst_o,
  output logic       tx_rst_o
);

  localparam int TRIG_DEF_I = (DEPTH / 4) * 3;
  localparam logic [7:0] TRIG_DEF = TRIG_DEF_I[7:0];

  logic rx_rst_req, tx_rst_req;
  assign rx_rst_req = ctrl_wr && rx_rst_wd;
  assign tx_rst_req = ctrl_wr && tx_rst_wd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bits  <= '0;
      rx_trig  <= TRIG_DEF;
      tx_trig  <= TRIG_DEF;
      rx_rst_o <= 1'b0;
      tx_rst_o <= 1'b0;
    end else begin
      if (en_wr) en_bits <= en_wd;
      if (ctrl_wr) begin
        rx_trig <= rx_trig_wd;
        tx_trig <= tx_trig_wd;
      end
      rx_rst_o <= rx_rst_req;
      tx_rst_o <= tx_rst_req;
    end
  end

  assert_rx_strobe_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_o |-> $past(ctrl_wr && rx_rst_wd));
  assert_tx_strobe_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_rst_o |-> $past(ctrl_wr && tx_rst_wd));
  assert_trig_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(rx_trig) && $stable(tx_trig));

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fic_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [1:0]               reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [$clog2(DEPTH):0]   rx_level,
  input  logic [$clog2(DEPTH):0]   tx_level,
  input  logic                     rx_ovf_pulse,
  input  logic                     xfer_done_pulse,
  output logic [NUM_FLAGS-1:0]     flags_o,
  output logic                     rx_fifo_clr,
  output logic                     tx_fifo_clr,
  output logic                     irq
);

  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [31:0] FLAG_MASK = 32'h0000_1111;

  // Named internal events, visible to the assertions.
  logic                 wr_en_reg, wr_sts_reg, wr_ctrl_reg;
  logic                 rx_hit, tx_hit;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, en_bits;
  logic [7:0]           rx_trig, tx_trig;
  logic                 unused_wdata;

  assign wr_en_reg   = reg_wr_en && (reg_addr == ADDR_EN);
  assign wr_sts_reg  = reg_wr_en && (reg_addr == ADDR_STS);
  assign wr_ctrl_reg = reg_wr_en && (reg_addr == ADDR_CTRL);
  assign unused_wdata = ^{reg_wdata[30:24], reg_wdata[14:13], reg_wdata[11:9],
                          reg_wdata[7:5], reg_wdata[3:1]};

  assign rx_hit  = fill_reached(9'(rx_level), 9'(rx_trig));
  assign tx_hit  = fill_drained(9'(tx_level), 9'(tx_trig));
  assign set_vec = {xfer_done_pulse, rx_ovf_pulse, tx_hit, rx_hit};
  assign clr_vec = wr_sts_reg ? gather_flags(reg_wdata) : '0;

  fic_ctrl_regs #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_wr      (wr_en_reg),
    .ctrl_wr    (wr_ctrl_reg),
    .en_wd      (gather_flags(reg_wdata)),
    .rx_trig_wd (reg_wdata[7:0]),
    .tx_trig_wd (reg_wdata[TX_TRIG_LSB +: 8]),
    .rx_rst_wd  (reg_wdata[RX_RST_BIT]),
    .tx_rst_wd  (reg_wdata[TX_RST_BIT]),
    .en_bits    (en_bits),
    .rx_trig    (rx_trig),
    .tx_trig    (tx_trig),
    .rx_rst_o   (rx_fifo_clr),
    .tx_rst_o   (tx_fifo_clr)
  );

  // Flags 0 and 1 follow FIFO levels; flags 2 and 3 capture pulses.
  generate
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      fic_flag_cell #(.LEVEL_SRC(i < 2)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec[i]),
        .clr_i  (clr_vec[i]),
        .flag_o (flags_o[i])
      );
    end
  endgenerate

  assign irq = |(flags_o & en_bits);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_EN:   reg_rdata = spread_flags(en_bits);
      ADDR_STS:  reg_rdata = spread_flags(flags_o);
      ADDR_CTRL: begin
        reg_rdata[7:0]                = rx_trig;
        reg_rdata[TX_TRIG_LSB +: 8]   = tx_trig;
      end
      ADDR_LVL: begin
        reg_rdata[CW-1:0]             = rx_level;
        reg_rdata[TX_TRIG_LSB +: CW]  = tx_level;
      end
      default:   reg_rdata = '0;
    endcase
  end

  assert_rx_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit && !clr_vec[0]) |=> flags_o[0]);
  assert_tx_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_hit && !clr_vec[1]) |=> flags_o[1]);
  assert_all_ones_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts_reg && (reg_wdata == 32'hFFFF_FFFF) && !rx_ovf_pulse && !xfer_done_pulse)
      |=> (flags_o[3:2] == 2'b00));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_bits == '0) |-> !irq);
  assert_en_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_EN) |-> ((reg_rdata & ~FLAG_MASK) == 32'h0));
  assert_rst_bits_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_CTRL) |-> (!reg_rdata[RX_RST_BIT] && !reg_rdata[TX_RST_BIT]));

endmodule

// File: tb/fifo_irq_ctrl_bench.sv
module fifo_irq_ctrl_bench;

  localparam int DEPTH = 64;
  localparam int CW    = $clog2(DEPTH) + 1;
  localparam int TRIG0 = DEPTH * 3 / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [CW-1:0] rx_level = '0;
  logic [CW-1:0] tx_level = '0;
  logic          rx_ovf_pulse = 1'b0;
  logic          xfer_done_pulse = 1'b0;
  logic [3:0]    flags_o;
  logic          rx_fifo_clr, tx_fifo_clr, irq;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Bench model state
  logic [3:0] m_flags, m_en;
  logic [7:0] m_rxt, m_txt;
  logic       m_rxs, m_txs;

  always #10 clk = ~clk;

  fifo_irq_ctrl #(.DEPTH(DEPTH)) u_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
    .tx_level(tx_level), .rx_ovf_pulse(rx_ovf_pulse),
    .xfer_done_pulse(xfer_done_pulse), .flags_o(flags_o),
    .rx_fifo_clr(rx_fifo_clr), .tx_fifo_clr(tx_fifo_clr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] flags_word(input logic [3:0] f);
    return {19'd0, f[3], 3'd0, f[2], 3'd0, f[1], 3'd0, f[0]};
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] a);
    case (a)
      2'd0:    return flags_word(m_en);
      2'd1:    return flags_word(m_flags);
      2'd2:    return {8'd0, m_txt, 8'd0, m_rxt};
      default: return (32'(tx_level) << 16) | 32'(rx_level);
    endcase
  endfunction

  task automatic model_reset();
    m_flags = '0; m_en = '0; m_rxt = 8'(TRIG0); m_txt = 8'(TRIG0);
    m_rxs = 0; m_txs = 0;
  endtask

  task automatic drv(input logic wr, input logic [1:0] a, input logic [31:0] d,
                     input logic ovf, input logic dn);
    reg_wr_en = wr; reg_addr = a; reg_wdata = d;
    rx_ovf_pulse = ovf; xfer_done_pulse = dn;
  endtask

  // One clock: check read data, advance the model, check registered outputs.
  task automatic tick();
    logic [3:0] nf, clr;
    logic       wsts, wen, wctl;
    #1;
    chk("R2 R11 R12 rdata", reg_rdata, exp_rdata(reg_addr));
    wsts = reg_wr_en && reg_addr == 2'd1;
    wen  = reg_wr_en && reg_addr == 2'd0;
    wctl = reg_wr_en && reg_addr == 2'd2;
    clr  = wsts ? {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]} : 4'd0;
    nf = m_flags;
    if (clr[0]) nf[0] = 0; else if (int'(rx_level) >= int'(m_rxt)) nf[0] = 1;
    if (clr[1]) nf[1] = 0; else if (int'(tx_level) <= int'(m_txt)) nf[1] = 1;
    if (rx_ovf_pulse) nf[2] = 1; else if (clr[2]) nf[2] = 0;
    if (xfer_done_pulse) nf[3] = 1; else if (clr[3]) nf[3] = 0;
    @(posedge clk);
    m_flags = nf;
    if (wen) m_en = {reg_wdata[12], reg_wdata[8], reg_wdata[4], reg_wdata[0]};
    if (wctl) begin m_rxt = reg_wdata[7:0]; m_txt = reg_wdata[23:16]; end
    m_rxs = wctl && reg_wdata[15];
    m_txs = wctl && reg_wdata[31];
    @(negedge clk);
    chk("R3 R4 R5 R6 R7 R8 flags", 32'(flags_o), 32'(m_flags));
    chk("R9 irq", 32'(irq), 32'(|(m_flags & m_en)));
    chk("R10 strobes", {30'd0, tx_fifo_clr, rx_fifo_clr}, {30'd0, m_txs, m_rxs});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    model_reset();
    // R1: reset state while reset is held
    repeat (3) @(negedge clk);
    reg_addr = 2'd2; #1;
    chk("R1 trig reset", reg_rdata, (32'(TRIG0) << 16) | 32'(TRIG0));
    chk("R1 flags reset", 32'(flags_o), 32'd0);
    chk("R1 irq reset", 32'(irq), 32'd0);
    chk("R1 strobes reset", {30'd0, tx_fifo_clr, rx_fifo_clr}, 32'd0);
    reg_addr = 2'd0; #1;
    chk("R1 enable reset", reg_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1;
    rx_level = '0; tx_level = CW'(DEPTH);
    drv(0, 2'd1, 0, 0, 0); tick();

    // R2: enable write masks reserved bits
    drv(1, 2'd0, 32'hFFFF_FFFF, 0, 0); tick();
    drv(0, 2'd0, 0, 0, 0); #1;
    chk("R2 enable readback", reg_rdata, 32'h0000_1111);

    // R3 boundary: count equal to trigger sets ready
    rx_level = CW'(TRIG0 - 1); tick();
    chk("R3 below trigger", 32'(flags_o[0]), 32'd0);
    rx_level = CW'(TRIG0); tick();
    chk("R3 at trigger", 32'(flags_o[0]), 32'd1);
    chk("R9 irq from ready", 32'(irq), 32'd1);

    // R7: clear while condition holds -> one low cycle, then set again
    drv(1, 2'd1, 32'h1, 0, 0); tick();
    chk("R7 low after clear", 32'(flags_o[0]), 32'd0);
    drv(0, 2'd1, 0, 0, 0); tick();
    chk("R7 set again", 32'(flags_o[0]), 32'd1);

    // R4 boundary
    tx_level = CW'(TRIG0 + 1); drv(1, 2'd1, 32'h10, 0, 0); tick();
    drv(0, 2'd1, 0, 0, 0); tick();
    chk("R4 above trigger", 32'(flags_o[1]), 32'd0);
    tx_level = CW'(TRIG0); tick();
    chk("R4 at trigger", 32'(flags_o[1]), 32'd1);

    // R8: overflow pulse with its own clear survives
    drv(1, 2'd1, 32'h100, 1, 0); tick();
    chk("R8 event beats clear", 32'(flags_o[2]), 32'd1);
    drv(1, 2'd1, 32'h100, 0, 0); tick();
    chk("R6 overflow cleared", 32'(flags_o[2]), 32'd0);

    // R5 + R6: done captured and held, all-ones clears everything
    rx_level = '0; tx_level = CW'(DEPTH);
    drv(0, 2'd1, 0, 0, 1); tick();
    drv(0, 2'd1, 0, 0, 0); tick(); tick();
    chk("R5 done held", 32'(flags_o[3]), 32'd1);
    drv(1, 2'd1, 32'hFFFF_FFFF, 0, 0); tick();
    chk("R6 all ones clears", 32'(flags_o), 32'd0);

    // R9: only the done enable set
    drv(1, 2'd0, 32'h1000, 0, 0); tick();
    drv(0, 2'd1, 0, 1, 0); tick();
    chk("R9 masked flag no irq", 32'(irq), 32'd0);
    drv(0, 2'd1, 0, 0, 1); tick();
    chk("R9 enabled flag irq", 32'(irq), 32'd1);

    // R10: reset strobes are one cycle and read zero
    drv(1, 2'd2, 32'h8000_0000 | (32'(TRIG0) << 16) | 32'h8000 | 32'(TRIG0), 0, 0); tick();
    chk("R10 rx strobe", 32'(rx_fifo_clr), 32'd1);
    chk("R10 tx strobe", 32'(tx_fifo_clr), 32'd1);
    drv(0, 2'd2, 0, 0, 0); tick();
    chk("R10 strobe ends", {30'd0, tx_fifo_clr, rx_fifo_clr}, 32'd0);
    chk("R10 bits read zero", reg_rdata, (32'(TRIG0) << 16) | 32'(TRIG0));

    // R11: live fill counts
    rx_level = CW'(37); tx_level = CW'(5); reg_addr = 2'd3; #1;
    chk("R11 levels", reg_rdata, 32'h0005_0025);
    rx_level = CW'(DEPTH); tx_level = CW'(DEPTH); #1;
    chk("R11 full levels", reg_rdata, (32'(DEPTH) << 16) | 32'(DEPTH));

    // Random mix
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d;
      logic [1:0]  a;
      a = 2'($urandom_range(3, 0));
      d = $urandom();
      if (a == 2'd1 && $urandom_range(3, 0) == 0) d = 32'hFFFF_FFFF;
      if (a == 2'd2) d[23:16] = 8'($urandom_range(DEPTH, 0));
      if (a == 2'd2) d[7:0]   = 8'($urandom_range(DEPTH, 0));
      rx_level = CW'($urandom_range(DEPTH, 0));
      tx_level = CW'($urandom_range(DEPTH, 0));
      drv($urandom_range(3, 0) == 0, a, d,
          $urandom_range(7, 0) == 0, $urandom_range(7, 0) == 0);
      tick();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule